// File: doc/BRIEF.md
# GPIO Pin Function and Output Level Register Bank

This block is the register side of a general-purpose pin controller for 54 pins. A host reaches it over a plain 32-bit word bus (byte address, write enable, read strobe, write data, registered read data). Each pin has a 3-bit function field. Ten fields are packed into each of six select words. The output level of the pins is held in two bank words. A host changes a level through a set word or a clear word, which alter only the masked bits, so one pin can be changed without a read-modify-write. Two level words read the latched state back. Four pull-configuration words are plain storage with fixed reset values.

The block drives a 54-bit pin output vector. A pin's bit follows its latched level only while the pin's function is output, and it is 0 in any other function. The block also drives a route bit that steers an SD card bus between two host controllers. The route bit changes only after a select-word write leaves pins 48 to 53 agreeing on a single function. If all six are input, the route goes to the first controller. If all six are alt0, it goes to the second. Any mixture leaves the route where it was.

Top module: `gpio_regbank`

## Requirements
- R1: While reset is asserted and after it is released, every function field is 0 (input), both level words are 0, the pin output vector is 0, sd_route is 0 (first controller) and bus_rdata is 0. The pull words hold 0xAAA95555, 0xA0AAAAAA, 0x50AAA95A and 0x00055555 at word offsets 0xE4, 0xE8, 0xEC and 0xF0.
- R2: The select word at byte offset 4·r (r = 0..5) holds the field of pin 10·r+i at bits 3i+2:3i. A write stores every field that belongs to an existing pin. A read returns those fields. Bits 31:30 read as zero, and so do the fields for pin numbers 54 and above (word 0x14 reads only bits 11:0).
- R3: A write to set word 0x1C ORs the written mask into the level of pins 0–31. A write to set word 0x20 ORs bits 21:0 into pins 32–53. Clear words 0x28 and 0x2C clear the masked bits of the same banks. The level changes for every masked bit, whatever the pin's function. Set and clear words read as zero. No other write changes a level.
- R4: Level word 0x34 reads the levels of pins 0–31. Level word 0x38 reads pins 32–53 in bits 21:0, with bits 31:22 zero. Writes to the level words change nothing.
- R5: Bit p of pin_out equals the latched level of pin p when the function of pin p is 1 (output), and is 0 otherwise. This holds at all times, so switching a pin to output presents its stored level.
- R6: On a select-word write, sd_route becomes 0 if pins 48–53 all end up with function 0. It becomes 1 if they all end up with function 4 (alt0). Otherwise it keeps its value. sd_route never changes without a select-word write.
- R7: The four pull words are read/write storage. A write replaces the whole word, and a read returns the last value written.
- R8: The event and enable region (0x40–0x8C), the gap words (0x18, 0x24, 0x30, 0x3C) and every other unmapped offset read as zero and ignore writes.
- R9: bus_rdata is loaded on the clock edge where bus_re is high, with the value before any write in that same cycle. It holds its value while bus_re is low. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the accessed word |
| bus_we | input | 1 | Write enable, acts on the clock edge |
| bus_re | input | 1 | Read strobe, data valid after the edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_out | output | 54 | Pin output vector, level gated by output function |
| sd_route | output | 1 | SD bus route: 0 first controller, 1 second controller |

## Verification
The bench builds the route group in two steps, because pins 48–53 span two select words. Writing alt0 into the first word alone must not move the route. A design that looks at each word in isolation, or that tests the stale fields, would switch too early or never switch. After the route is set, a write that spoils the group with one mismatched field must leave the route in place, and a design that reset it on "not all alt0" would flip back. The bench sets and clears levels on pins that are not in output mode and then switches them to output. A design that gated the level update by function, instead of the output, would show the wrong levels. Wide writes to word 0x14 and to the second-bank set word check that non-existent pins stay zero. Same-cycle read-and-write checks that the read returns the pre-write value.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;

  typedef enum logic [2:0] {
    FN_IN   = 3'd0,
    FN_OUT  = 3'd1,
    FN_ALT5 = 3'd2,
    FN_ALT4 = 3'd3,
    FN_ALT0 = 3'd4,
    FN_ALT1 = 3'd5,
    FN_ALT2 = 3'd6,
    FN_ALT3 = 3'd7
  } pin_fn_e;

  localparam int PIN_FSEL_W      = 3;
  localparam int FIELDS_PER_WORD = 10;
  localparam int BANK_BITS       = 32;
  localparam int PULL_WORDS      = 4;

  // word indices (byte offset / 4)
  localparam int W_SET0  = 7;
  localparam int W_CLR0  = 10;
  localparam int W_LEV0  = 13;
  localparam int W_PULL0 = 57;

  localparam logic [PULL_WORDS*32-1:0] PULL_RESET =
    {32'h0005_5555, 32'h50AA_A95A, 32'hA0AA_AAAA, 32'hAAA9_5555};

  function automatic int words_for(input int n, input int per);
    return (n + per - 1) / per;
  endfunction

  function automatic int field_pin(input int r, input int f);
    return r * FIELDS_PER_WORD + f;
  endfunction

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/gpio_fsel_bank.sv
module gpio_fsel_bank
  import gpio_regbank_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int FSEL_W   = PIN_FSEL_W,
  parameter int FPR      = FIELDS_PER_WORD,
  parameter int NREG     = 6,
  parameter int IDX_W    = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [31:0]                wdata,
  input  logic [IDX_W-1:0]           rd_idx,
  output logic [31:0]                rd_word,
  output logic [NUM_PINS*FSEL_W-1:0] fsel_q,
  output logic [NUM_PINS*FSEL_W-1:0] fsel_d,
  output logic [NUM_PINS-1:0]        out_mask
);

  logic [31:0] packed_w [NREG];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int R = p / FPR;
    localparam int F = p % FPR;
    logic hit;
    assign hit = wr_en && (32'(wr_idx) == R);
    assign fsel_d[p*FSEL_W +: FSEL_W] =
      hit ? wdata[F*FSEL_W +: FSEL_W] : fsel_q[p*FSEL_W +: FSEL_W];
    assign out_mask[p] = (fsel_q[p*FSEL_W +: FSEL_W] == FSEL_W'(FN_OUT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fsel_q <= '0;
    else        fsel_q <= fsel_d;
  end

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      packed_w[r] = '0;
      for (int f = 0; f < FPR; f++) begin
        if (field_pin(r, f) < NUM_PINS)
          packed_w[r][f*FSEL_W +: FSEL_W] = fsel_q[field_pin(r, f)*FSEL_W +: FSEL_W];
      end
    end
  end

  assign rd_word = (32'(rd_idx) < NREG) ? packed_w[rd_idx] : '0;

endmodule

// File: rtl/gpio_level_bank.sv
module gpio_level_bank #(
  parameter int NUM_PINS = 54,
  parameter int BANK_W   = 32,
  parameter int NBANK    = 2,
  parameter int BIDX_W   = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic                clr_en,
  input  logic [BIDX_W-1:0]   bank,
  input  logic [BANK_W-1:0]   mask,
  output logic [NUM_PINS-1:0] level_q
);

  localparam int LW = NBANK * BANK_W;

  logic [LW-1:0]       wide;
  logic [NUM_PINS-1:0] pin_mask;
  logic [NUM_PINS-1:0] level_d;
  logic                unused_hi;

  assign wide      = LW'(mask) << (bank * BANK_W);
  assign pin_mask  = wide[NUM_PINS-1:0];
  assign unused_hi = ^wide;

  always_comb begin
    level_d = level_q;
    if (set_en)      level_d = level_q | pin_mask;
    else if (clr_en) level_d = level_q & ~pin_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_d;
  end

endmodule

// File: rtl/gpio_sd_route.sv
module gpio_sd_route
  import gpio_regbank_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int FSEL_W   = PIN_FSEL_W,
  parameter int GRP_LO   = 48,
  parameter int GRP_N    = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sel_wr,
  input  logic [NUM_PINS*FSEL_W-1:0] fsel_d,
  output logic                       route_q
);

  logic              all_in;
  logic              all_alt0;
  logic [FSEL_W-1:0] fld;

  always_comb begin
    all_in   = 1'b1;
    all_alt0 = 1'b1;
    fld      = '0;
    for (int k = 0; k < GRP_N; k++) begin
      fld      = fsel_d[(GRP_LO+k)*FSEL_W +: FSEL_W];
      all_in   = all_in   & (fld == FSEL_W'(FN_IN));
      all_alt0 = all_alt0 & (fld == FSEL_W'(FN_ALT0));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) route_q <= 1'b0;
    else if (sel_wr) begin
      if (all_in)        route_q <= 1'b0;
      else if (all_alt0) route_q <= 1'b1;
    end
  end

endmodule

// File: rtl/gpio_pull_regs.sv
module gpio_pull_regs #(
  parameter int                   NPULL    = 4,
  parameter int                   IDX_W    = 2,
  parameter logic [NPULL*32-1:0]  RST_VALS = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [31:0]        wdata,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [31:0]        rd_word,
  output logic [NPULL*32-1:0] pull_flat
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pull_flat <= RST_VALS;
    else if (wr_en) pull_flat[wr_idx*32 +: 32] <= wdata;
  end

  assign rd_word = pull_flat[rd_idx*32 +: 32];

endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_regbank_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic                bus_re,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [NUM_PINS-1:0] pin_out,
  output logic                sd_route
);

  localparam int FSEL_W = PIN_FSEL_W;
  localparam int FPR    = FIELDS_PER_WORD;
  localparam int NREG   = words_for(NUM_PINS, FPR);
  localparam int FIDX_W = idx_w(NREG);
  localparam int BANK_W = BANK_BITS;
  localparam int NBANK  = words_for(NUM_PINS, BANK_W);
  localparam int BIDX_W = idx_w(NBANK);
  localparam int NPULL  = PULL_WORDS;
  localparam int PIDX_W = idx_w(NPULL);
  localparam int LW     = NBANK * BANK_W;

  // address decode
  logic [31:0] widx;
  logic        unused_lsb;
  logic        is_fsel, is_set, is_clr, is_lev, is_pull;
  assign widx       = 32'(bus_addr[ADDR_W-1:2]);
  assign unused_lsb = ^bus_addr[1:0];
  assign is_fsel = (widx < NREG);
  assign is_set  = (widx >= W_SET0)  && (widx < W_SET0 + NBANK);
  assign is_clr  = (widx >= W_CLR0)  && (widx < W_CLR0 + NBANK);
  assign is_lev  = (widx >= W_LEV0)  && (widx < W_LEV0 + NBANK);
  assign is_pull = (widx >= W_PULL0) && (widx < W_PULL0 + NPULL);

  logic [FIDX_W-1:0] fsel_idx;
  logic [BIDX_W-1:0] set_b, clr_b, lev_b, lvl_bank;
  logic [PIDX_W-1:0] pull_idx;
  assign fsel_idx = FIDX_W'(widx);
  assign set_b    = BIDX_W'(widx - W_SET0);
  assign clr_b    = BIDX_W'(widx - W_CLR0);
  assign lev_b    = BIDX_W'(widx - W_LEV0);
  assign pull_idx = PIDX_W'(widx - W_PULL0);
  assign lvl_bank = is_set ? set_b : clr_b;

  // named internal events
  logic sel_wr, set_wr, clr_wr, lvl_wr, pull_wr;
  assign sel_wr  = bus_we & is_fsel;
  assign set_wr  = bus_we & is_set;
  assign clr_wr  = bus_we & is_clr;
  assign lvl_wr  = set_wr | clr_wr;
  assign pull_wr = bus_we & is_pull;

  logic [NUM_PINS*FSEL_W-1:0] fsel_q, fsel_d;
  logic [NUM_PINS-1:0]        out_mask;
  logic [NUM_PINS-1:0]        level_q;
  logic [NPULL*32-1:0]        pull_flat;
  logic [31:0]                fsel_word, pull_word, lev_word;
  logic [LW-1:0]              lev_wide;

  gpio_fsel_bank #(
    .NUM_PINS(NUM_PINS), .FSEL_W(FSEL_W), .FPR(FPR), .NREG(NREG), .IDX_W(FIDX_W)
  ) u_fsel (
    .clk(clk), .rst_n(rst_n), .wr_en(sel_wr), .wr_idx(fsel_idx), .wdata(bus_wdata),
    .rd_idx(fsel_idx), .rd_word(fsel_word), .fsel_q(fsel_q), .fsel_d(fsel_d),
    .out_mask(out_mask)
  );

  gpio_level_bank #(
    .NUM_PINS(NUM_PINS), .BANK_W(BANK_W), .NBANK(NBANK), .BIDX_W(BIDX_W)
  ) u_level (
    .clk(clk), .rst_n(rst_n), .set_en(set_wr), .clr_en(clr_wr), .bank(lvl_bank),
    .mask(bus_wdata), .level_q(level_q)
  );

  gpio_sd_route #(
    .NUM_PINS(NUM_PINS), .FSEL_W(FSEL_W), .GRP_LO(48), .GRP_N(6)
  ) u_route (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .fsel_d(fsel_d), .route_q(sd_route)
  );

  gpio_pull_regs #(
    .NPULL(NPULL), .IDX_W(PIDX_W), .RST_VALS(PULL_RESET)
  ) u_pull (
    .clk(clk), .rst_n(rst_n), .wr_en(pull_wr), .wr_idx(pull_idx), .wdata(bus_wdata),
    .rd_idx(pull_idx), .rd_word(pull_word), .pull_flat(pull_flat)
  );

  assign lev_wide = LW'(level_q);
  assign lev_word = lev_wide[lev_b*BANK_W +: BANK_W];

  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (is_fsel)      rd_val = fsel_word;
    else if (is_lev)  rd_val = lev_word;
    else if (is_pull) rd_val = pull_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_val;
  end

  assign pin_out = level_q & out_mask;

endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk #(
  parameter int NUM_PINS = 54,
  parameter int PULL_W   = 128
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_re,
  input logic [31:0]         bus_rdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] out_mask,
  input logic [NUM_PINS-1:0] level_q,
  input logic                sd_route,
  input logic                sel_wr,
  input logic                lvl_wr,
  input logic                pull_wr,
  input logic [PULL_W-1:0]   pull_flat
);

  p_pins_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~out_mask) == '0);

  p_pins_sub_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~level_q) == '0);

  p_level_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_wr |=> $stable(level_q));

  p_route_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_wr |=> $stable(sd_route));

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));

  p_pull_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pull_wr |=> $stable(pull_flat));

endmodule

bind gpio_regbank gpio_regbank_chk #(.NUM_PINS(NUM_PINS), .PULL_W(NPULL*32)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_re(bus_re), .bus_rdata(bus_rdata),
  .pin_out(pin_out), .out_mask(out_mask), .level_q(level_q), .sd_route(sd_route),
  .sel_wr(sel_wr), .lvl_wr(lvl_wr), .pull_wr(pull_wr), .pull_flat(pull_flat)
);

// File: tb/sim_gpio_regbank.sv
`timescale 1ns/1ps
module sim_gpio_regbank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [53:0] pin_out;
  logic        sd_route;

  always #2.5 clk = ~clk;

  gpio_regbank u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out), .sd_route(sd_route)
  );

  // behavioural reference
  int          m_fn [54];
  bit [53:0]   m_lev;
  bit          m_route;
  bit [31:0]   m_pull [4];
  bit [31:0]   m_rd;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    checking = 0;
  bit    done = 0;
  string cur_req = "R1";

  function automatic bit [31:0] m_read(bit [7:0] a);
    bit [31:0] v = 0;
    int w = int'(a) / 4;
    if (w <= 5) begin
      for (int i = 0; i < 10; i++)
        if (w * 10 + i < 54) v = v | (32'(m_fn[w*10+i]) << (3 * i));
    end else if (w == 13) v = m_lev[31:0];
    else if (w == 14) v = {10'b0, m_lev[53:32]};
    else if (w >= 57 && w <= 60) v = m_pull[w-57];
    return v;
  endfunction

  function automatic void m_write(bit [7:0] a, bit [31:0] d);
    int w = int'(a) / 4;
    bit ai, aa;
    if (w <= 5) begin
      for (int i = 0; i < 10; i++)
        if (w * 10 + i < 54) m_fn[w*10+i] = int'((d >> (3 * i)) & 32'h7);
      ai = 1; aa = 1;
      for (int p = 48; p < 54; p++) begin
        ai = ai & (m_fn[p] == 0);
        aa = aa & (m_fn[p] == 4);
      end
      if (ai) m_route = 0;
      else if (aa) m_route = 1;
    end else if (w == 7)  m_lev[31:0]  = m_lev[31:0] | d;
    else if (w == 8)  m_lev[53:32] = m_lev[53:32] | d[21:0];
    else if (w == 10) m_lev[31:0]  = m_lev[31:0] & ~d;
    else if (w == 11) m_lev[53:32] = m_lev[53:32] & ~d[21:0];
    else if (w >= 57 && w <= 60) m_pull[w-57] = d;
  endfunction

  function automatic bit [53:0] m_pins();
    bit [53:0] v;
    for (int p = 0; p < 54; p++) v[p] = m_lev[p] && (m_fn[p] == 1);
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 54; p++) m_fn[p] = 0;
      m_lev = 0; m_route = 0; m_rd = 0;
      m_pull[0] = 32'hAAA95555; m_pull[1] = 32'hA0AAAAAA;
      m_pull[2] = 32'h50AAA95A; m_pull[3] = 32'h00055555;
    end else begin
      if (bus_re) m_rd = m_read(bus_addr & 8'hFC);
      if (bus_we) m_write(bus_addr & 8'hFC, bus_wdata);
    end
  end

  always @(negedge clk) begin
    if (checking && !done) begin
      n_cmp++;
      if (bus_rdata !== m_rd) begin
        n_bad++;
        $display("FAIL %s rdata actual=%h expected=%h", cur_req, bus_rdata, m_rd);
      end
      n_cmp++;
      if (pin_out !== m_pins()) begin
        n_bad++;
        $display("FAIL %s pin_out actual=%h expected=%h", cur_req, pin_out, m_pins());
      end
      n_cmp++;
      if (sd_route !== m_route) begin
        n_bad++;
        $display("FAIL %s sd_route actual=%b expected=%b", cur_req, sd_route, m_route);
      end
    end
  end

  task automatic op(bit we, bit re, bit [7:0] a, bit [31:0] d);
    @(negedge clk);
    bus_we = we; bus_re = re; bus_addr = a; bus_wdata = d;
  endtask
  task automatic wr(bit [7:0] a, bit [31:0] d); op(1, 0, a, d); endtask
  task automatic rd(bit [7:0] a); op(0, 1, a, 0); endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) op(0, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  localparam bit [31:0] ALL_OUT = 32'h0924_9249;

  initial begin
    bit [7:0] addrs [18] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h1C, 8'h20,
                             8'h28, 8'h2C, 8'h34, 8'h38, 8'h40, 8'hE4, 8'hF0, 8'h90,
                             8'hFC, 8'h18};
    repeat (3) @(posedge clk);
    @(negedge clk);
    checking = 1;          // R1: outputs under reset
    @(negedge clk);
    rst_n = 1;
    // R1: every register after reset
    cur_req = "R1";
    for (int a = 0; a < 8'h40; a += 4) rd(8'(a));
    for (int a = 8'hE4; a <= 8'hF0; a += 4) rd(8'(a));
    idle(2);

    // R2: packing and non-existent fields
    cur_req = "R2";
    wr(8'h00, 32'h1234_5678); rd(8'h00);
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h08);
    wr(8'h14, 32'hFFFF_FFFF); rd(8'h14);
    wr(8'h14, 32'h0000_0000); rd(8'h14);
    wr(8'h00, 32'h0); wr(8'h08, 32'h0);
    idle(1);

    // R3 and R5: levels on non-output pins, then switch to output
    cur_req = "R3";
    wr(8'h1C, 32'hA5A5_0F0F); rd(8'h34); rd(8'h1C);
    wr(8'h20, 32'hFFFF_FFFF); rd(8'h38); rd(8'h20);
    wr(8'h28, 32'h0000_00FF); rd(8'h34); rd(8'h28);
    wr(8'h2C, 32'h0000_0003); rd(8'h38); rd(8'h2C);
    cur_req = "R5";
    wr(8'h00, ALL_OUT); wr(8'h0C, ALL_OUT); wr(8'h14, ALL_OUT);
    idle(1);
    wr(8'h28, 32'hFFFF_0000); wr(8'h1C, 32'h0000_F000);
    wr(8'h00, 32'h0000_0000); idle(1);
    wr(8'h2C, 32'h003F_0000); wr(8'h20, 32'h0001_0000);

    // R4: level words ignore writes
    cur_req = "R4";
    wr(8'h34, 32'hFFFF_FFFF); rd(8'h34);
    wr(8'h38, 32'h0000_0000); rd(8'h38);

    // R6: route group spread over two select words
    cur_req = "R6";
    wr(8'h10, 32'h2400_0000); idle(1);           // pins 48,49 alt0 only
    wr(8'h14, 32'h0000_0924); idle(1);           // 50..53 alt0 -> second
    wr(8'h14, 32'h0000_0923); idle(1);           // mixture holds
    wr(8'h10, 32'h0000_0000); idle(1);           // 48,49 input, 50..53 mixed
    wr(8'h14, 32'h0000_0924); wr(8'h10, 32'h2400_0000); idle(1);
    wr(8'h08, 32'h0); idle(1);                   // unrelated write holds
    wr(8'h10, 32'h0000_0000); wr(8'h14, 32'h0); idle(1); // all input -> first

    // R7: pull words
    cur_req = "R7";
    wr(8'hE4, 32'h1357_9BDF); wr(8'hF0, 32'hDEAD_BEEF);
    rd(8'hE4); rd(8'hE8); rd(8'hEC); rd(8'hF0);

    // R8: unmapped and event words
    cur_req = "R8";
    wr(8'h40, 32'hFFFF_FFFF); rd(8'h40);
    wr(8'h4C, 32'hFFFF_FFFF); rd(8'h4C);
    wr(8'h8C, 32'hFFFF_FFFF); rd(8'h8C);
    wr(8'h18, 32'hFFFF_FFFF); rd(8'h18);
    wr(8'hFC, 32'hFFFF_FFFF); rd(8'hFC);
    rd(8'h00); rd(8'h34); rd(8'hE4);

    // R9: hold, same-cycle read and write, ignored low address bits
    cur_req = "R9";
    rd(8'hE4); idle(3);
    op(1, 1, 8'hE4, 32'h0BAD_F00D); idle(1); rd(8'hE4);
    rd(8'hE7); wr(8'h1D, 32'h0000_0001); rd(8'h36);
    idle(2);

    // mixed traffic
    cur_req = "R5";
    for (int n = 0; n < 600; n++) begin
      bit [7:0]  a = addrs[$urandom_range(0, 17)];
      bit [31:0] d = $urandom;
      if (a <= 8'h14 && ($urandom_range(0, 2) == 0)) d = ALL_OUT;
      op($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, a, d);
    end
    idle(3);
    finish_run();
  end

endmodule